// File: doc/BRIEF.md
# Four-Level Bus Arbiter with Selectable Policy

This block sits in the system controller of a shared backplane bus. It watches four request lines, one per priority level numbered 0 to 3. It hands out one grant line per level, and only while the bus-busy input is low. The winning master takes the bus by raising bus busy. The arbiter then withdraws the grant and does not arbitrate again until bus busy falls. Ordering among masters that share one level is left to an external grant daisy chain.

A mode input, sampled at run time, picks the policy. In single-level mode only one configured level is served. In priority mode the highest pending level wins, and the arbiter raises a bus-clear output to ask the current owner to yield when a higher level is waiting. In round-robin mode levels are visited in strictly descending cyclic order. All pins are plain control signals. The request lines are levels rather than a valid/ready stream, so there is no back-pressure: a request simply stays high until it is served.

Top module: `lvl_bus_arbiter`

## Requirements
- R1: While reset is active, and on the first cycle after it, every grant line and bus clear are low.
- R2: At most one grant line is high in any cycle.
- R3: A grant is only raised on the clock edge after a cycle in which bus busy was sampled low. While bus busy stays high, no grant appears, whatever requests are pending.
- R4: Once raised, a grant stays high, even if its request drops, until bus busy is sampled high. It is low on the next cycle, and no new grant is issued until bus busy is sampled low again.
- R5: Mode 2'b00 (single-level): only the request at the level given by `single_lvl_i` is served. Requests at other levels are ignored.
- R6: Mode 2'b01 (priority): the highest pending level wins, with level 3 highest and level 0 lowest.
- R7: In priority mode, bus clear rises one cycle after a cycle in which the bus is owned (grant taken), bus busy is high and some request is above the owner's level. It is low one cycle after bus busy is sampled low. It is never raised in other modes, and never for a request at or below the owner's level.
- R8: Mode 2'b10 (round robin): the search starts one level below the last granted level and goes downward, wrapping from 0 to 3. The last granted level is served again only if it is the sole requester. After reset the last level counts as 0, so level 3 is searched first. The last granted level is recorded on every grant.
- R9: With no requests, no grant is issued, and the recorded last level does not change.
- R10: Mode 2'b11 is reserved and issues no grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Policy: 00 single, 01 priority, 10 round robin, 11 reserved |
| single_lvl_i | input | 2 | Level served in single-level mode |
| req_i | input | 4 | Bus request, bit n is level n |
| busy_i | input | 1 | Bus busy, high while a master owns the bus |
| grant_o | output | 4 | Bus grant, bit n is level n |
| clear_o | output | 1 | Request for the current owner to release the bus |

## Verification
A corrupted state register would show as a grant that lingers after bus busy rises, or as a second grant issued under a busy bus. Either shows up at the ports within one cycle of the busy transition. A stale owner level shows as a wrong bus clear one cycle after bus busy is high with a waiting request. A damaged round-robin pointer goes unseen until the next round-robin grant, which then lands on a level other than the next lower pending one. The bench therefore runs full descending sequences, idle gaps and wrap-around cases.

// File: rtl/lvlarb_pkg.sv
package lvlarb_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_PRIO   = 2'b01,
    MODE_RROBIN = 2'b10,
    MODE_NONE   = 2'b11
  } arb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_OFFER = 2'b01,
    ST_OWNED = 2'b10
  } arb_state_e;
endpackage

// File: rtl/lvlarb_pick.sv
module lvlarb_pick
  import lvlarb_pkg::*;
#(
  parameter int NLVL = 4,
  localparam int LW = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] req,
  input  arb_mode_e       mode,
  input  logic [LW-1:0]   single_lvl,
  input  logic [LW-1:0]   rr_ptr,
  output logic            hit,
  output logic [LW-1:0]   lvl
);
  logic [NLVL-1:0] mask;
  logic [NLVL-1:0] elig;
  logic            hit_prio, hit_rr;
  logic [LW-1:0]   lvl_prio, lvl_rr;
  logic [LW-1:0]   rot_idx [NLVL];

  // candidate order for rotation: ptr-1, ptr-2, ..., ptr
  for (genvar k = 0; k < NLVL; k++) begin : g_rot
    assign rot_idx[k] = LW'((int'(rr_ptr) + NLVL - 1 - k) % NLVL);
  end

  always_comb begin
    mask = '0;
    case (mode)
      MODE_SINGLE: mask[single_lvl] = 1'b1;
      MODE_PRIO,
      MODE_RROBIN: mask = '1;
      default:     mask = '0;
    endcase
    elig = req & mask;

    hit_prio = 1'b0;
    lvl_prio = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (elig[i]) begin
        hit_prio = 1'b1;
        lvl_prio = LW'(i);
      end
    end

    hit_rr = 1'b0;
    lvl_rr = '0;
    for (int k = NLVL - 1; k >= 0; k--) begin
      if (elig[rot_idx[k]]) begin
        hit_rr = 1'b1;
        lvl_rr = rot_idx[k];
      end
    end

    if (mode == MODE_RROBIN) begin
      hit = hit_rr;
      lvl = lvl_rr;
    end else begin
      hit = hit_prio;
      lvl = lvl_prio;
    end
  end
endmodule

// File: rtl/lvlarb_fsm.sv
module lvlarb_fsm
  import lvlarb_pkg::*;
#(
  parameter int NLVL = 4,
  localparam int LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            hit,
  input  logic [LW-1:0]   lvl,
  output logic [NLVL-1:0] grant,
  output logic [LW-1:0]   owner,
  output logic [LW-1:0]   rr_ptr,
  output logic            owned
);
  arb_state_e st;
  logic       fire;

  assign fire  = hit && !busy && (st != ST_OFFER);
  assign owned = (st == ST_OWNED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      grant  <= '0;
      owner  <= '0;
      rr_ptr <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_OWNED: begin
          if (!busy) begin
            if (fire) begin
              grant  <= NLVL'(1) << lvl;
              owner  <= lvl;
              rr_ptr <= lvl;
              st     <= ST_OFFER;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_OFFER: begin
          if (busy) begin
            grant <= '0;
            st    <= ST_OWNED;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !busy) |=> (grant == $past(grant))); // R4
  AST_TAKEN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && busy) |=> (grant == '0)); // R4
endmodule

// File: rtl/lvlarb_clear.sv
module lvlarb_clear
  import lvlarb_pkg::*;
#(
  parameter int NLVL = 4,
  localparam int LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  arb_mode_e       mode,
  input  logic            busy,
  input  logic [NLVL-1:0] req,
  input  logic            owned,
  input  logic [LW-1:0]   owner,
  output logic            clear
);
  logic [NLVL-1:0] above;

  for (genvar i = 0; i < NLVL; i++) begin : g_above
    assign above[i] = req[i] && (LW'(i) > owner);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) clear <= 1'b0;
    else        clear <= (mode == MODE_PRIO) && owned && busy && (|above);
  end

  AST_CLR_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !clear); // R7
  AST_CLR_PRIO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> ($past(mode) == MODE_PRIO)); // R7
endmodule

// File: rtl/lvl_bus_arbiter.sv
module lvl_bus_arbiter
  import lvlarb_pkg::*;
#(
  parameter int NLVL = 4,
  localparam int LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic [LW-1:0]   single_lvl_i,
  input  logic [NLVL-1:0] req_i,
  input  logic            busy_i,
  output logic [NLVL-1:0] grant_o,
  output logic            clear_o
);
  arb_mode_e     mode;
  logic          hit;
  logic [LW-1:0] lvl, owner, rr_ptr;
  logic          owned;

  assign mode = arb_mode_e'(mode_i);

  lvlarb_pick #(.NLVL(NLVL)) u_pick (
    .req(req_i), .mode(mode), .single_lvl(single_lvl_i), .rr_ptr(rr_ptr),
    .hit(hit), .lvl(lvl)
  );

  lvlarb_fsm #(.NLVL(NLVL)) u_fsm (
    .clk(clk), .rst_n(rst_n), .busy(busy_i), .hit(hit), .lvl(lvl),
    .grant(grant_o), .owner(owner), .rr_ptr(rr_ptr), .owned(owned)
  );

  lvlarb_clear #(.NLVL(NLVL)) u_clear (
    .clk(clk), .rst_n(rst_n), .mode(mode), .busy(busy_i), .req(req_i),
    .owned(owned), .owner(owner), .clear(clear_o)
  );

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R2
  AST_GRANT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|grant_o) |-> !$past(busy_i)); // R3
  AST_SINGLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|grant_o) && $past(mode_i) == 2'b00) |-> grant_o[$past(single_lvl_i)]); // R5
  AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0 && req_i == '0) |=> (grant_o == '0)); // R9
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == 2'b11) |-> !$rose(|grant_o)); // R10
endmodule

// File: tb/lvl_bus_arbiter_bench.sv
`timescale 1ns/1ps
module lvl_bus_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [1:0] single_lvl_i = 2'd0;
  logic [3:0] req_i = '0;
  logic       busy_i = 1'b0;
  logic [3:0] grant_o;
  logic       clear_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lvl_bus_arbiter u_lvl_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .single_lvl_i(single_lvl_i),
    .req_i(req_i), .busy_i(busy_i), .grant_o(grant_o), .clear_o(clear_o)
  );

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; req_i = '0; busy_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // expect grant exp on the next negedge, then take and release the bus
  task automatic take(string tag, logic [3:0] exp);
    @(negedge clk);
    chk(tag, grant_o, exp);
    busy_i = 1'b1;
    @(negedge clk);
    chk({tag, " drop"}, grant_o, 4'b0000);
    busy_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_i = 4'b1111; mode_i = 2'b01;
    repeat (2) @(negedge clk);
    chk("R1 grant in reset", grant_o, 4'b0000);
    chk("R1 clear in reset", {3'b000, clear_o}, 4'b0000);
    req_i = '0; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grant after reset", grant_o, 4'b0000);
    chk("R1 clear after reset", {3'b000, clear_o}, 4'b0000);
  endtask

  task automatic t_block_hold();
    mode_i = 2'b01; apply_reset();
    busy_i = 1'b1; req_i = 4'b0010;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 no grant while busy", grant_o, 4'b0000);
    end
    busy_i = 1'b0;
    @(negedge clk);
    chk("R3 grant after busy low", grant_o, 4'b0010);
    req_i = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 grant held", grant_o, 4'b0010);
    end
    busy_i = 1'b1;
    @(negedge clk);
    chk("R4 grant dropped on busy", grant_o, 4'b0000);
    req_i = 4'b1000;
    repeat (2) begin
      @(negedge clk);
      chk("R4 no regrant while owned", grant_o, 4'b0000);
    end
    busy_i = 1'b0;
    @(negedge clk);
    chk("R4 regrant after release", grant_o, 4'b1000);
    req_i = '0; busy_i = 1'b1;
    @(negedge clk);
    busy_i = 1'b0;
  endtask

  task automatic t_single();
    mode_i = 2'b00; single_lvl_i = 2'd2; apply_reset();
    req_i = 4'b1011;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 other levels ignored", grant_o, 4'b0000);
    end
    req_i = 4'b0100;
    take("R5 configured level served", 4'b0100);
    req_i = '0;
  endtask

  task automatic t_prio();
    mode_i = 2'b01; apply_reset();
    req_i = 4'b0110; take("R6 level2 over level1", 4'b0100);
    req_i = 4'b0011; take("R6 level1 over level0", 4'b0010);
    req_i = 4'b1111; take("R6 level3 highest", 4'b1000);
    req_i = '0;
  endtask

  task automatic t_clear();
    mode_i = 2'b01; apply_reset();
    req_i = 4'b0001;
    @(negedge clk);
    chk("R7 low grant", grant_o, 4'b0001);
    busy_i = 1'b1;
    @(negedge clk);
    chk("R7 no clear at take", {3'b000, clear_o}, 4'b0000);
    req_i = 4'b1000;
    @(negedge clk);
    chk("R7 clear raised", {3'b000, clear_o}, 4'b0001);
    @(negedge clk);
    chk("R7 clear kept", {3'b000, clear_o}, 4'b0001);
    busy_i = 1'b0;
    @(negedge clk);
    chk("R7 clear falls", {3'b000, clear_o}, 4'b0000);
    chk("R7 higher level granted", grant_o, 4'b1000);
    busy_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 no clear for same level", {3'b000, clear_o}, 4'b0000);
    busy_i = 1'b0; req_i = '0;
    mode_i = 2'b10; apply_reset();
    req_i = 4'b1000;
    @(negedge clk);
    busy_i = 1'b1; req_i = 4'b0000;
    @(negedge clk);
    mode_i = 2'b10; req_i = 4'b1000;
    repeat (2) @(negedge clk);
    chk("R7 no clear in round robin", {3'b000, clear_o}, 4'b0000);
    busy_i = 1'b0; req_i = '0;
    @(negedge clk);
  endtask

  task automatic t_rr();
    mode_i = 2'b10; apply_reset();
    req_i = 4'b1111;
    take("R8 first is level3", 4'b1000);
    take("R8 then level2", 4'b0100);
    take("R8 then level1", 4'b0010);
    take("R8 then level0", 4'b0001);
    take("R8 wrap to level3", 4'b1000);
    req_i = 4'b1100; take("R8 next lower pending", 4'b0100);
    take("R8 skip to level3", 4'b1000);
    req_i = 4'b1000; take("R8 sole requester repeats", 4'b1000);
    req_i = '0;
  endtask

  task automatic t_idle_ptr();
    mode_i = 2'b10; apply_reset();
    req_i = 4'b1111;
    take("R9 setup level3", 4'b1000);
    req_i = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 no grant without requests", grant_o, 4'b0000);
    end
    req_i = 4'b1111;
    take("R9 pointer kept", 4'b0100);
    req_i = '0;
  endtask

  task automatic t_reserved();
    mode_i = 2'b11; apply_reset();
    req_i = 4'b1111;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 reserved mode silent", grant_o, 4'b0000);
    end
    mode_i = 2'b01;
    take("R10 grant after leaving reserved", 4'b1000);
    req_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_block_hold();
    t_single();
    t_prio();
    t_clear();
    t_rr();
    t_idle_ptr();
    t_reserved();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule